// File: doc/BRIEF.md
# SDRAM Low-Power Entry and Exit Sequencer

This block sits between a memory controller and the clock-enable and command pins of a DDR SDRAM. When the controller asks for sleep, the block waits for the read/write pipeline to be idle, then holds clock enable high for one guard cycle while a NOP goes out. After that it drives clock enable low together with the command that picks the low-power state. An auto-refresh command picks self refresh. A NOP picks power-down, which is active power-down when a bank has an open row and precharge power-down when every bank is idle.

While the memory is asleep, clock enable stays low and the command bus is pinned to NOP. Every controller command and request is ignored, except a wake request. On wake, the block raises clock enable with one NOP and then hands the bus back to the controller, marking with `ready` the first cycle in which a real command may be issued. In the running state the controller's command passes straight through with no added latency. All pins are plain control and status, so there is no valid/ready stream and no back-pressure.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset, `cke` is 1, `ready` is 1, `mode` is 0 and `cmd_out` equals `cmd_in`.
- R2: While `ready` is 1, `cmd_out` follows `cmd_in` in the same cycle. Commands are 4 bits wide, {cs_n, ras_n, cas_n, we_n}.
- R3: While `busy` is 1, `sleep_req` has no effect and `cke` stays 1. After `busy` falls, entry starts only once `busy` has been low for IDLE_CYCLES full cycles (default 1). With the default, the guard cycle begins at the second clock edge after `busy` falls.
- R4: Entry begins with exactly one guard cycle in which `cke` is 1, `cmd_out` is NOP (4'b0111), `ready` is 0 and `mode` is 0.
- R5: In the cycle after the guard cycle, `cke` is 0. `cmd_out` is auto-refresh (4'b0001) when `self_req` was 1 at the end of the guard cycle, and NOP otherwise. `mode` becomes 3 for self refresh, 2 when `bank_open` was 1, and 1 otherwise. 0 means running.
- R6: If `busy` is 1 at the end of the guard cycle, entry is cancelled. The block returns to running on the next cycle, and `cke` never goes low.
- R7: While asleep, `cke` stays 0, `cmd_out` stays NOP and `mode` stays constant, whatever `cmd_in`, `sleep_req`, `self_req` and `bank_open` do.
- R8: A `wake_req` seen while asleep gives one exit cycle with `cke` 1, `cmd_out` NOP, `ready` 0 and `mode` unchanged. In the next cycle `ready` is 1 and `mode` is 0.
- R9: `wake_req` has no effect while running, during the guard cycle, or in the cycle in which `cke` first goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter a low-power state |
| self_req | input | 1 | 1 selects self refresh, 0 selects power-down |
| wake_req | input | 1 | Request to leave the low-power state |
| busy | input | 1 | A read or write burst is in progress |
| bank_open | input | 1 | At least one bank holds an open row |
| cmd_in | input | 4 | Controller command {cs_n, ras_n, cas_n, we_n} |
| cke | output | 1 | Clock enable to the memory |
| cmd_out | output | 4 | Command to the memory {cs_n, ras_n, cas_n, we_n} |
| ready | output | 1 | Controller may issue a command this cycle |
| mode | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
The command pass-through is combinational, so it is sampled in the same cycle the command is driven. The guard cycle appears one edge after a qualified sleep request, and the low-`cke` cycle with its mode code one edge after that. The exit cycle follows one edge after `wake_req`, and `ready` returns one edge after the exit cycle. The bench drives inputs on the falling edge and counts rising edges one at a time with a step task, so every check reads the outputs in the exact cycle each result is due, half a period away from the edge that produced it.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_NOP  = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_AREF = 4'b0001;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_ARM  = 3'd1,
    ST_DROP = 3'd2,
    ST_DOWN = 3'd3,
    ST_RISE = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'd0,
    LPM_PRE  = 2'd1,
    LPM_ACT  = 2'd2,
    LPM_SELF = 2'd3
  } lp_mode_e;
endpackage

// File: rtl/lp_idle_gate.sv
module lp_idle_gate #(
  parameter int IDLE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic sleep_req,
  output logic go
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (busy)             quiet_cnt <= '0;
    else if (quiet_cnt != CNT_MAX) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign go = sleep_req && !busy && (quiet_cnt == CNT_MAX);
endmodule

// File: rtl/lp_state_ctl.sv
module lp_state_ctl
  import lp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       busy,
  input  logic       wake_req,
  input  logic       self_req,
  input  logic       bank_open,
  output seq_state_e state,
  output lp_mode_e   mode_q
);
  seq_state_e state_nx;
  lp_mode_e   mode_nx;

  always_comb begin
    state_nx = state;
    mode_nx  = mode_q;
    unique case (state)
      ST_RUN:  if (go) state_nx = ST_ARM;
      ST_ARM: begin
        if (busy) state_nx = ST_RUN;
        else begin
          state_nx = ST_DROP;
          if (self_req)       mode_nx = LPM_SELF;
          else if (bank_open) mode_nx = LPM_ACT;
          else                mode_nx = LPM_PRE;
        end
      end
      ST_DROP: state_nx = ST_DOWN;
      ST_DOWN: if (wake_req) state_nx = ST_RISE;
      ST_RISE: begin
        state_nx = ST_RUN;
        mode_nx  = LPM_RUN;
      end
      default: begin
        state_nx = ST_RUN;
        mode_nx  = LPM_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      mode_q <= LPM_RUN;
    end else begin
      state  <= state_nx;
      mode_q <= mode_nx;
    end
  end
endmodule

// File: rtl/lp_bus_drive.sv
module lp_bus_drive
  import lp_seq_pkg::*;
(
  input  seq_state_e       state,
  input  lp_mode_e         mode_q,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             cke,
  output logic [CMD_W-1:0] cmd_out,
  output logic             ready
);
  always_comb begin
    cke     = 1'b1;
    cmd_out = CMD_NOP;
    ready   = 1'b0;
    unique case (state)
      ST_RUN: begin
        cmd_out = cmd_in;
        ready   = 1'b1;
      end
      ST_DROP: begin
        cke     = 1'b0;
        cmd_out = (mode_q == LPM_SELF) ? CMD_AREF : CMD_NOP;
      end
      ST_DOWN: cke = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_seq_pkg::*;
#(
  parameter int IDLE_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             self_req,
  input  logic             wake_req,
  input  logic             busy,
  input  logic             bank_open,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             cke,
  output logic [CMD_W-1:0] cmd_out,
  output logic             ready,
  output logic [1:0]       mode
);
  logic       go;
  seq_state_e state;
  lp_mode_e   mode_q;

  lp_idle_gate #(.IDLE_CYCLES(IDLE_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sleep_req(sleep_req), .go(go)
  );

  lp_state_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .wake_req(wake_req),
    .self_req(self_req), .bank_open(bank_open), .state(state), .mode_q(mode_q)
  );

  lp_bus_drive u_drv (
    .state(state), .mode_q(mode_q), .cmd_in(cmd_in),
    .cke(cke), .cmd_out(cmd_out), .ready(ready)
  );

  assign mode = mode_q;
endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk
  import lp_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [CMD_W-1:0] cmd_in,
  input logic             cke,
  input logic [CMD_W-1:0] cmd_out,
  input logic             ready,
  input logic [1:0]       mode
);
  // R2
  running_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && mode == 2'd0 && cmd_out == cmd_in));

  // R4
  guard_before_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(cmd_out) == CMD_NOP && !$past(ready) && mode != 2'd0));

  // R5
  self_uses_aref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke) && mode == 2'd3) |-> cmd_out == CMD_AREF);

  // R5
  pd_uses_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke) && mode != 2'd3) |-> cmd_out == CMD_NOP);

  // R7
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$past(cke)) |-> (cmd_out == CMD_NOP && $stable(mode)));

  // R8
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_out == CMD_NOP && !ready && mode != 2'd0));

  // R8
  exit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> (ready && mode == 2'd0));

  // R3
  busy_keeps_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && busy) |=> cke);
endmodule

bind lp_mode_seq lp_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_in(cmd_in), .cke(cke),
  .cmd_out(cmd_out), .ready(ready), .mode(mode)
);

// File: tb/sim_lp_mode_seq.sv
module sim_lp_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0, self_req = 1'b0, wake_req = 1'b0;
  logic       busy = 1'b0, bank_open = 1'b0;
  logic [3:0] cmd_in = 4'b1111;
  logic       cke, ready;
  logic [3:0] cmd_out;
  logic [1:0] mode;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] AREF = 4'b0001;

  always #4 clk = ~clk;

  lp_mode_seq u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .self_req(self_req),
    .wake_req(wake_req), .busy(busy), .bank_open(bank_open), .cmd_in(cmd_in),
    .cke(cke), .cmd_out(cmd_out), .ready(ready), .mode(mode)
  );

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_state(input string tag, input int e_cke, input int e_rdy,
                           input int e_mode, input int e_cmd);
    chk({tag, " cke"}, cke, e_cke);
    chk({tag, " ready"}, ready, e_rdy);
    chk({tag, " mode"}, mode, e_mode);
    chk({tag, " cmd"}, cmd_out, e_cmd);
  endtask

  task automatic do_exit(input int code);
    wake_req = 1'b1;
    step(1);
    chk_state("R8 exit cycle", 1, 0, code, NOP);
    wake_req = 1'b0;
    step(1);
    chk_state("R8 back to run", 1, 1, 0, cmd_in);
  endtask

  task automatic t_reset();
    step(1);
    chk_state("R1 in reset", 1, 1, 0, cmd_in);
    rst_n = 1'b1;
    step(1);
    chk_state("R1 after reset", 1, 1, 0, cmd_in);
    cmd_in = 4'b0101;
    #1 chk("R2 pass a", cmd_out, 4'b0101);
    cmd_in = 4'b0010;
    #1 chk("R2 pass b", cmd_out, 4'b0010);
    step(1);
  endtask

  task automatic t_precharge_pd();
    busy = 1'b1; sleep_req = 1'b1; self_req = 1'b0; bank_open = 1'b0;
    step(4);
    chk_state("R3 held by busy", 1, 1, 0, cmd_in);
    busy = 1'b0;
    step(1);
    chk_state("R3 first quiet cycle", 1, 1, 0, cmd_in);
    step(1);
    chk_state("R4 guard", 1, 0, 0, NOP);
    step(1);
    chk_state("R5 precharge pd drop", 0, 0, 1, NOP);
    sleep_req = 1'b0;
    step(1);
    chk_state("R7 asleep", 0, 0, 1, NOP);
    cmd_in = 4'b0011; bank_open = 1'b1; sleep_req = 1'b1; self_req = 1'b1;
    step(3);
    chk_state("R7 inputs ignored", 0, 0, 1, NOP);
    sleep_req = 1'b0; self_req = 1'b0; bank_open = 1'b0;
    do_exit(1);
  endtask

  task automatic t_active_pd();
    bank_open = 1'b1; sleep_req = 1'b1;
    step(1);
    chk_state("R4 guard act", 1, 0, 0, NOP);
    sleep_req = 1'b0;
    step(1);
    chk_state("R5 active pd drop", 0, 0, 2, NOP);
    step(2);
    chk_state("R7 asleep act", 0, 0, 2, NOP);
    bank_open = 1'b0;
    do_exit(2);
  endtask

  task automatic t_self();
    self_req = 1'b1; bank_open = 1'b1; sleep_req = 1'b1;
    step(1);
    chk_state("R4 guard self", 1, 0, 0, NOP);
    sleep_req = 1'b0;
    step(1);
    chk_state("R5 self refresh drop", 0, 0, 3, AREF);
    step(1);
    chk_state("R7 self asleep", 0, 0, 3, NOP);
    self_req = 1'b0; bank_open = 1'b0;
    do_exit(3);
  endtask

  task automatic t_cancel();
    sleep_req = 1'b1;
    step(1);
    chk_state("R6 guard", 1, 0, 0, NOP);
    busy = 1'b1;
    step(1);
    chk_state("R6 cancelled", 1, 1, 0, cmd_in);
    step(3);
    chk_state("R6 stays running", 1, 1, 0, cmd_in);
    busy = 1'b0; sleep_req = 1'b0;
    step(2);
  endtask

  task automatic t_wake_ignored();
    wake_req = 1'b1;
    step(2);
    chk_state("R9 wake while running", 1, 1, 0, cmd_in);
    sleep_req = 1'b1;
    step(1);
    chk_state("R9 guard with wake", 1, 0, 0, NOP);
    sleep_req = 1'b0;
    step(1);
    chk_state("R9 drop with wake", 0, 0, 1, NOP);
    wake_req = 1'b0;
    step(1);
    chk_state("R9 asleep after wake in drop", 0, 0, 1, NOP);
    do_exit(1);
  endtask

  initial begin
    t_reset();
    t_precharge_pd();
    t_active_pd();
    t_self();
    t_cancel();
    t_wake_ignored();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1..all watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule